// File: doc/BRIEF.md
# ECC Syndrome Checker and Single-Bit Corrector

This block takes the 24-bit Hamming-style check code that was read back from a flash spare area and the code freshly computed over the matching 256-byte data chunk. It compares them and sorts the outcome into one of four classes: clean, a fault inside the check code itself, a single data-bit error that can be repaired, or damage that cannot be repaired. When the error is repairable, the block reports which byte and which bit inside that byte failed. It then repairs the buffered data itself with a read followed by a write on a simple byte-wide memory port.

A request can cover one chunk or a whole two-chunk page. In page mode the block handles chunk 0 first and chunk 1 second. Each chunk is checked against its own pair of codes, and each chunk gives its own result pulse. Generating the check codes is done elsewhere.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: Chunk k takes its codes from bits [24k+23:24k] of `calc_i` and `stored_i`. The three code bytes are little-endian, so the byte at bits [7:0] of a slice is the least significant. Code bits 10:0 form one parity half and bits 21:11 form the complementary half.
- R2: The result is status 0 (clean) when the two codes are equal, or when either code is all zeros. A clean chunk makes no memory access.
- R3: Let the syndrome be the XOR of the two 24-bit codes. When exactly one syndrome bit is set, the result is status 1 (check-code fault) and the data is left untouched.
- R4: When the syndrome has exactly eleven bits set and every bit i of the syndrome (i = 0..10) differs from bit i+11, the result is status 2 (corrected). In that case `fix_bit_o` is syndrome bits 2:0 and `fix_byte_o` is syndrome bits 10:3.
- R5: For status 2, the block issues a read at address {chunk, failing byte}. It expects the read data on `mem_rdata_i` in the following cycle. In that following cycle it writes to the same address the read data with only the failing bit inverted.
- R6: Any other syndrome gives status 3 (uncorrectable) and makes no memory access.
- R7: A start is accepted only while `busy_o` is low. `busy_o` is high from the cycle after the accepting edge until the end of the last result cycle. The classification is registered at the first edge after acceptance. `done_o` pulses for one cycle per chunk: 2 cycles after the accepting edge for statuses 0, 1 and 3, and 4 cycles after it for status 2. `status_o`, `res_chunk_o`, `fix_byte_o` and `fix_bit_o` are valid during that pulse.
- R8: With `multi_i` high at start, chunk 1 is evaluated in the cycle right after chunk 0's result pulse. Its result carries `res_chunk_o` = 1 and its repair address has bit 8 set. With `multi_i` low, only chunk 0 is processed.
- R9: While busy, changes on `start_i`, `multi_i`, `calc_i` and `stored_i` have no effect. The codes and the mode are captured at the accepting edge.
- R10: During and after reset, and whenever no request is active, `busy_o`, `done_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken when idle |
| multi_i | input | 1 | 1: process both chunks of the page; 0: chunk 0 only |
| calc_i | input | 48 | Freshly computed codes, 24 bits per chunk |
| stored_i | input | 48 | Codes read from the spare area, 24 bits per chunk |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle result pulse per chunk |
| status_o | output | 2 | 0 clean, 1 code fault, 2 corrected, 3 uncorrectable |
| res_chunk_o | output | 1 | Chunk the result belongs to |
| fix_byte_o | output | 8 | Failing byte index inside the chunk |
| fix_bit_o | output | 3 | Failing bit inside that byte |
| mem_req_o | output | 1 | Data-buffer access strobe |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 9 | Buffer byte address {chunk, byte} |
| mem_wdata_o | output | 8 | Repaired byte |
| mem_rdata_i | input | 8 | Read data, one cycle after a read strobe |

## Verification
The bench builds the block with its defaults: 8-bit data, 11-bit parity halves, three code bytes and two chunks per page. This gives the full 0..255 byte index and bit 7 of a byte, so repairs at byte 0 bit 0 and at byte 255 bit 7 can be checked. With two chunks, page mode can check the second chunk's address bit and the back-to-back result pulses. A mixed case is also covered: a clean first chunk followed by an unrepairable second chunk.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

  // Outcome of one chunk comparison; the encoding is visible on status_o.
  typedef enum logic [1:0] {
    CLS_CLEAN    = 2'd0,
    CLS_CODE_ERR = 2'd1,
    CLS_FIXED    = 2'd2,
    CLS_FATAL    = 2'd3
  } cls_e;

  // Sequencer phases.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_EVAL  = 3'd1,
    PH_READ  = 3'd2,
    PH_WRITE = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W  = 24,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] ones_o
);

  always_comb begin
    ones_o = '0;
    for (int i = 0; i < W; i++) begin
      ones_o = ones_o + CW'(vec_i[i]);
    end
  end

endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import ecc_fix_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int CODE_W = 24,
  parameter int BIT_W  = 3,
  parameter int IDX_W  = HALF_W - BIT_W
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output cls_e              cls_o,
  output logic [IDX_W-1:0]  byte_o,
  output logic [BIT_W-1:0]  bit_o
);

  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [HALF_W-1:0] low_syn;
  logic [HALF_W-1:0] calc_fold;
  logic [HALF_W-1:0] stored_fold;
  logic [CNT_W-1:0]  syn_ones;
  logic              any_zero;
  logic              halves_paired;

  assign syn         = calc_i ^ stored_i;
  assign low_syn     = calc_i[HALF_W-1:0] ^ stored_i[HALF_W-1:0];
  assign calc_fold   = calc_i[HALF_W-1:0] ^ calc_i[2*HALF_W-1:HALF_W];
  assign stored_fold = stored_i[HALF_W-1:0] ^ stored_i[2*HALF_W-1:HALF_W];

  assign any_zero      = (syn == '0) || (calc_i == '0) || (stored_i == '0);
  assign halves_paired = ((calc_fold ^ stored_fold) == {HALF_W{1'b1}});

  ecc_popcount #(.W(CODE_W), .CW(CNT_W)) u_pop (
    .vec_i  (syn),
    .ones_o (syn_ones)
  );

  always_comb begin
    if (any_zero) begin
      cls_o = CLS_CLEAN;
    end else if (syn_ones == CNT_W'(1)) begin
      cls_o = CLS_CODE_ERR;
    end else if ((syn_ones == CNT_W'(HALF_W)) && halves_paired) begin
      cls_o = CLS_FIXED;
    end else begin
      cls_o = CLS_FATAL;
    end
  end

  assign bit_o  = low_syn[BIT_W-1:0];
  assign byte_o = low_syn[HALF_W-1:BIT_W];

endmodule

// File: rtl/ecc_code_bank.sv
module ecc_code_bank #(
  parameter int CODE_W = 24,
  parameter int CHUNKS = 2,
  parameter int SEL_W  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [CODE_W*CHUNKS-1:0] calc_i,
  input  logic [CODE_W*CHUNKS-1:0] stored_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [CODE_W-1:0]        calc_o,
  output logic [CODE_W-1:0]        stored_o
);

  logic [CHUNKS-1:0][CODE_W-1:0] calc_w;
  logic [CHUNKS-1:0][CODE_W-1:0] stored_w;

  for (genvar g = 0; g < CHUNKS; g++) begin : g_slot
    logic [CODE_W-1:0] calc_q;
    logic [CODE_W-1:0] stored_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        calc_q   <= '0;
        stored_q <= '0;
      end else if (load_i) begin
        calc_q   <= calc_i[g*CODE_W +: CODE_W];
        stored_q <= stored_i[g*CODE_W +: CODE_W];
      end
    end

    assign calc_w[g]   = calc_q;
    assign stored_w[g] = stored_q;
  end

  assign calc_o   = calc_w[sel_i];
  assign stored_o = stored_w[sel_i];

endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_fix_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3,
  parameter int IDX_W  = 8,
  parameter int CHUNKS = 2,
  parameter int SEL_W  = 1,
  parameter int ADDR_W = IDX_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              multi_i,
  input  cls_e              cls_i,
  input  logic [IDX_W-1:0]  cls_byte_i,
  input  logic [BIT_W-1:0]  cls_bit_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              load_o,
  output logic [SEL_W-1:0]  chunk_o,
  output logic              busy_o,
  output logic              done_o,
  output cls_e              status_o,
  output logic [IDX_W-1:0]  fix_byte_o,
  output logic [BIT_W-1:0]  fix_bit_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  phase_e            state_q, state_d;
  logic [SEL_W-1:0]  chunk_q, chunk_d;
  logic              chunk_en;
  logic              multi_q;
  cls_e              status_q;
  logic [IDX_W-1:0]  byte_q;
  logic [BIT_W-1:0]  bit_q;
  logic              accept;
  logic              last_chunk;
  logic              res_en;
  logic [DATA_W-1:0] flip_mask;

  assign accept     = (state_q == PH_IDLE) && start_i;
  assign last_chunk = !multi_q || (chunk_q == SEL_W'(CHUNKS - 1));
  assign res_en     = (state_q == PH_EVAL);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:  if (start_i) state_d = PH_EVAL;
      PH_EVAL:  state_d = (cls_i == CLS_FIXED) ? PH_READ : PH_DONE;
      PH_READ:  state_d = PH_WRITE;
      PH_WRITE: state_d = PH_DONE;
      PH_DONE:  state_d = last_chunk ? PH_IDLE : PH_EVAL;
      default:  state_d = PH_IDLE;
    endcase
  end

  // Chunk pointer: cleared on acceptance, advanced after each non-final result
  always_comb begin
    chunk_en = 1'b0;
    chunk_d  = chunk_q;
    if (accept) begin
      chunk_en = 1'b1;
      chunk_d  = '0;
    end else if ((state_q == PH_DONE) && !last_chunk) begin
      chunk_en = 1'b1;
      chunk_d  = chunk_q + SEL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chunk_q <= '0;
    end else if (chunk_en) begin
      chunk_q <= chunk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      multi_q <= 1'b0;
    end else if (accept) begin
      multi_q <= multi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= CLS_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
    end else if (res_en) begin
      status_q <= cls_i;
      byte_q   <= cls_byte_i;
      bit_q    <= cls_bit_i;
    end
  end

  always_comb begin
    flip_mask        = '0;
    flip_mask[bit_q] = 1'b1;
  end

  assign load_o      = accept;
  assign chunk_o     = chunk_q;
  assign busy_o      = (state_q != PH_IDLE);
  assign done_o      = (state_q == PH_DONE);
  assign status_o    = status_q;
  assign fix_byte_o  = byte_q;
  assign fix_bit_o   = bit_q;
  assign mem_req_o   = (state_q == PH_READ) || (state_q == PH_WRITE);
  assign mem_we_o    = (state_q == PH_WRITE);
  assign mem_addr_o  = {chunk_q, byte_q};
  assign mem_wdata_o = mem_rdata_i ^ flip_mask;

endmodule

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer
  import ecc_fix_pkg::*;
#(
  parameter  int DATA_W     = 8,
  parameter  int HALF_W     = 11,
  parameter  int CODE_BYTES = 3,
  parameter  int CHUNKS     = 2,
  localparam int BIT_W      = $clog2(DATA_W),
  localparam int IDX_W      = HALF_W - BIT_W,
  localparam int CODE_W     = CODE_BYTES * 8,
  localparam int SEL_W      = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam int ADDR_W     = IDX_W + SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     multi_i,
  input  logic [CODE_W*CHUNKS-1:0] calc_i,
  input  logic [CODE_W*CHUNKS-1:0] stored_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [1:0]               status_o,
  output logic [SEL_W-1:0]         res_chunk_o,
  output logic [IDX_W-1:0]         fix_byte_o,
  output logic [BIT_W-1:0]         fix_bit_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic [DATA_W-1:0]        mem_rdata_i
);

  logic              load;
  logic [SEL_W-1:0]  chunk_sel;
  logic [CODE_W-1:0] calc_cur;
  logic [CODE_W-1:0] stored_cur;
  cls_e              cls;
  logic [IDX_W-1:0]  cls_byte;
  logic [BIT_W-1:0]  cls_bit;
  cls_e              status_e;

  ecc_code_bank #(
    .CODE_W (CODE_W),
    .CHUNKS (CHUNKS),
    .SEL_W  (SEL_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .calc_i   (calc_i),
    .stored_i (stored_i),
    .sel_i    (chunk_sel),
    .calc_o   (calc_cur),
    .stored_o (stored_cur)
  );

  ecc_classify #(
    .HALF_W (HALF_W),
    .CODE_W (CODE_W),
    .BIT_W  (BIT_W),
    .IDX_W  (IDX_W)
  ) u_cls (
    .calc_i   (calc_cur),
    .stored_i (stored_cur),
    .cls_o    (cls),
    .byte_o   (cls_byte),
    .bit_o    (cls_bit)
  );

  ecc_fix_seq #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W),
    .IDX_W  (IDX_W),
    .CHUNKS (CHUNKS),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .multi_i     (multi_i),
    .cls_i       (cls),
    .cls_byte_i  (cls_byte),
    .cls_bit_i   (cls_bit),
    .mem_rdata_i (mem_rdata_i),
    .load_o      (load),
    .chunk_o     (chunk_sel),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_e),
    .fix_byte_o  (fix_byte_o),
    .fix_bit_o   (fix_bit_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign status_o    = status_e;
  assign res_chunk_o = chunk_sel;

endmodule

// File: rtl/ecc_syndrome_fixer_chk.sv
module ecc_syndrome_fixer_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        status_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i
);

  // A write is always preceded by a read of the same address (R5)
  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> ($past(mem_req_o && !mem_we_o) && (mem_addr_o == $past(mem_addr_o))));

  // The written byte differs from the returned byte in exactly one bit (R5)
  assert_one_bit_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> ($countones(mem_wdata_o ^ mem_rdata_i) == 1));

  // A corrected result is reported right after its write (R4)
  assert_fixed_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (status_o == 2'd2)) |-> $past(mem_req_o && mem_we_o));

  // Clean, code-fault and uncorrectable results touch no memory (R2, R3, R6)
  assert_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (status_o != 2'd2)) |-> !$past(mem_req_o));

  // An accepted start makes the block busy (R7)
  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // Result pulses are never back to back (R7)
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // Idle block is quiet (R10)
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_req_o && !done_o));

endmodule

bind ecc_syndrome_fixer ecc_syndrome_fixer_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/ecc_syndrome_fixer_test.sv
`timescale 1ns/1ps
module ecc_syndrome_fixer_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        multi_i;
  logic [47:0] calc_i;
  logic [47:0] stored_i;
  logic        busy_o;
  logic        done_o;
  logic [1:0]  status_o;
  logic        res_chunk_o;
  logic [7:0]  fix_byte_o;
  logic [2:0]  fix_bit_o;
  logic        mem_req_o;
  logic        mem_we_o;
  logic [8:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;

  ecc_syndrome_fixer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .multi_i     (multi_i),
    .calc_i      (calc_i),
    .stored_i    (stored_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o),
    .res_chunk_o (res_chunk_o),
    .fix_byte_o  (fix_byte_o),
    .fix_bit_o   (fix_bit_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Data buffer: read data returns one cycle after the strobe
  logic [7:0] mem [512];
  int         ref_mem [512];

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i     <= mem[mem_addr_o];
    end
  end

  typedef struct packed {
    logic       busy;
    logic       req;
    logic       we;
    logic       done;
    logic [8:0] addr;
    logic [7:0] wdata;
    logic [1:0] status;
    logic       chunk;
    logic [7:0] fbyte;
    logic [2:0] fbit;
    logic [3:0] tag;
  } exp_t;

  exp_t q[$];
  int   checks   = 0;
  int   failures = 0;
  bit   mon_on   = 0;
  bit   finished = 0;

  function automatic string rn(int t);
    case (t)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(bit ok, int t, string what, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rn(t), what, act, expv);
    end
  endtask

  function automatic exp_t idle_e(int t);
    exp_t e;
    e     = '0;
    e.tag = 4'(t);
    return e;
  endfunction

  // Behavioural reference classification
  task automatic ref_cls(input logic [23:0] c, input logic [23:0] s,
                         output int st, output int fb, output int fbit);
    logic [23:0] x;
    int          n;
    bit          paired;
    x      = c ^ s;
    n      = 0;
    paired = 1;
    for (int i = 0; i < 24; i++) n += int'(x[i]);
    for (int i = 0; i < 11; i++) if (x[i] == x[i+11]) paired = 0;
    if (x == 0 || c == 0 || s == 0) st = 0;
    else if (n == 1)                st = 1;
    else if (n == 11 && paired)     st = 2;
    else                            st = 3;
    fb   = int'(x[10:3]);
    fbit = int'(x[2:0]);
  endtask

  // Syndrome of a repairable single-bit data error
  function automatic logic [23:0] corr_syn(int b, int bit_i);
    logic [10:0] lo;
    lo = {8'(b), 3'(bit_i)};
    return {2'b00, ~lo, lo};
  endfunction

  task automatic push_chunk(logic [23:0] c, logic [23:0] s, int ch, int tag_ov);
    int   st, fb, fbit, a, t;
    exp_t e;
    ref_cls(c, s, st, fb, fbit);
    case (st)
      0:       t = 2;
      1:       t = 3;
      2:       t = 4;
      default: t = 6;
    endcase
    if (tag_ov != 0) t = tag_ov;
    e      = '0;
    e.tag  = 4'(t);
    e.busy = 1;
    q.push_back(e);                       // evaluation cycle (R7)
    if (st == 2) begin
      a       = ch * 256 + fb;
      e.req   = 1;
      e.addr  = 9'(a);
      q.push_back(e);                     // read (R5)
      e.we    = 1;
      e.wdata = 8'(ref_mem[a] ^ (1 << fbit));
      q.push_back(e);                     // write (R5)
      ref_mem[a] = int'(e.wdata);
      e.req   = 0;
      e.we    = 0;
    end
    e.done   = 1;
    e.status = 2'(st);
    e.chunk  = 1'(ch);
    e.fbyte  = 8'(fb);
    e.fbit   = 3'(fbit);
    q.push_back(e);
  endtask

  task automatic run(logic [23:0] c0, logic [23:0] s0, logic [23:0] c1, logic [23:0] s1,
                     bit multi, int tag0, int tag1, bit poke);
    @(posedge clk); #2;
    calc_i   = {c1, c0};
    stored_i = {s1, s0};
    multi_i  = multi;
    start_i  = 1'b1;
    q.push_back(idle_e(7));
    push_chunk(c0, s0, 0, tag0);
    if (multi) push_chunk(c1, s1, 1, tag1);
    @(posedge clk); #2;
    start_i = 1'b0;
    if (poke) begin
      // R9: new request and new codes while busy must be ignored
      @(posedge clk); #2;
      start_i  = 1'b1;
      calc_i   = ~calc_i;
      stored_i = '0;
      multi_i  = 1'b1;
      @(posedge clk); #2;
      @(posedge clk); #2;
      start_i  = 1'b0;
    end
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // Cycle-by-cycle comparison against the reference queue
  always @(negedge clk) begin
    exp_t e;
    if (mon_on && !finished) begin
      if (q.size() != 0) e = q.pop_front();
      else               e = idle_e(10);
      chk(busy_o == e.busy, int'(e.tag), "busy_o", int'(busy_o), int'(e.busy));
      chk(mem_req_o == e.req, int'(e.tag), "mem_req_o", int'(mem_req_o), int'(e.req));
      chk(done_o == e.done, int'(e.tag), "done_o", int'(done_o), int'(e.done));
      if (e.req) begin
        chk(mem_we_o == e.we, int'(e.tag), "mem_we_o", int'(mem_we_o), int'(e.we));
        chk(mem_addr_o == e.addr, int'(e.tag), "mem_addr_o", int'(mem_addr_o), int'(e.addr));
      end
      if (e.req && e.we)
        chk(mem_wdata_o == e.wdata, int'(e.tag), "mem_wdata_o", int'(mem_wdata_o), int'(e.wdata));
      if (e.done) begin
        chk(status_o == e.status, int'(e.tag), "status_o", int'(status_o), int'(e.status));
        chk(res_chunk_o == e.chunk, int'(e.tag), "res_chunk_o", int'(res_chunk_o), int'(e.chunk));
        if (e.status == 2'd2) begin
          chk(fix_byte_o == e.fbyte, int'(e.tag), "fix_byte_o", int'(fix_byte_o), int'(e.fbyte));
          chk(fix_bit_o == e.fbit, int'(e.tag), "fix_bit_o", int'(fix_bit_o), int'(e.fbit));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL R7 watchdog expired actual=busy expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    for (int i = 0; i < 512; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      ref_mem[i] = (i * 7 + 3) & 255;
    end
    rst_n    = 1'b0;
    start_i  = 1'b0;
    multi_i  = 1'b0;
    calc_i   = '0;
    stored_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(busy_o == 1'b0, 10, "reset busy_o", int'(busy_o), 0);
    chk(done_o == 1'b0, 10, "reset done_o", int'(done_o), 0);
    chk(mem_req_o == 1'b0, 10, "reset mem_req_o", int'(mem_req_o), 0);
    @(posedge clk); #2;
    rst_n  = 1'b1;
    mon_on = 1;
    repeat (3) @(posedge clk);

    c = 24'h3CA51E;
    // R2: equal codes; stored code all zero
    run(c, c, 24'h0, 24'h0, 0, 0, 0, 0);
    run(c, 24'h0, 24'h0, 24'h0, 0, 0, 0, 0);
    // R3: single syndrome bit at the top and at the bottom
    run(c, c ^ 24'h800000, 24'h0, 24'h0, 0, 0, 0, 0);
    run(c, c ^ 24'h000001, 24'h0, 24'h0, 0, 0, 0, 0);
    // R1: byte-order sensitive repair at byte A7 bit 2
    run(c, c ^ corr_syn(8'hA7, 2), 24'h0, 24'h0, 0, 1, 0, 0);
    // R4: repairs at a middle point and at both index extremes
    run(c, c ^ corr_syn(8'h5A, 5), 24'h0, 24'h0, 0, 0, 0, 0);
    run(c, c ^ corr_syn(0, 0), 24'h0, 24'h0, 0, 0, 0, 0);
    run(c, c ^ corr_syn(255, 7), 24'h0, 24'h0, 0, 0, 0, 0);
    // R6: two low bits; eleven ones without pairing
    run(c, c ^ 24'h000003, 24'h0, 24'h0, 0, 0, 0, 0);
    run(c, c ^ 24'hC001FF, 24'h0, 24'h0, 0, 0, 0, 0);
    // R8: both chunks repaired; clean then uncorrectable; single-chunk mode
    run(c, c ^ corr_syn(3, 1), 24'h71B2C3, 24'h71B2C3 ^ corr_syn(200, 6), 1, 0, 8, 0);
    run(c, c, 24'h0F0F0F, 24'h0F0F0F ^ 24'h000300, 1, 0, 8, 0);
    run(c, c, 24'h0F0F0F, 24'h0F0F0F ^ corr_syn(9, 4), 0, 8, 0, 0);
    // R9: start and code changes while busy
    run(c, c ^ corr_syn(77, 3), 24'h0, 24'h0, 0, 9, 0, 1);
    repeat (4) @(posedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule